// File: doc/BRIEF.md
# Grouped Tree Pseudo-LRU Victim Selector with Random Group Draw

This block picks which way to evict in a 24-way set-associative cache. The ways of a set are split into three groups of eight consecutive ways. Each group keeps its own 7-bit binary-tree pseudo-LRU state, so every set stores 21 bits. There is no stored decision above the groups. On each miss, one of the three groups is drawn at random from a 16-bit LFSR. The victim is the leaf that the drawn group's tree points at.

The cache controller presents one request at a time. A request carries a set index and a hit flag. For a hit, it also carries the way that hit, and the selector refreshes that way's group tree. For a miss, the selector draws a group and returns the victim way one cycle later. It treats that victim as the line about to be filled, so it also refreshes that way in its tree.

A 2-bit draw can produce a value with no matching group. When that happens the LFSR is stepped again on the next cycle. While this retry is in progress, `busy_o` is held high and new requests are not taken.

Top module: `grp_plru_sel`

## Requirements
- R1: After reset, `victim_valid_o` and `busy_o` are low, every tree bit of every set is 0, and the LFSR holds 16'hACE1.
- R2: A reported victim is a way number `group*8 + leaf`, carried as {group[1:0], leaf[2:0]}, and it always lies in 0..23.
- R3: Tree nodes are numbered as a heap: node 0 is the root, and the children of node n are 2n+1 and 2n+2. Starting at the root, a node bit of 0 sends the walk to the left child and 1 to the right child. The leaf is built MSB first from the bits met on the way down, so an all-zero tree points at leaf 0.
- R4: A legal hit to way w sets each node on w's path to point away from w. It changes only the tree of group w/8 in the addressed set, and it produces no victim.
- R5: Each draw cycle uses the LFSR's low two bits as the group number, then steps the LFSR. The step is a right shift, and when the bit shifted out is 1 the result is XORed with 16'hB400.
- R6: A drawn value of 3 produces no victim. `busy_o` is high in the next cycle, and the draw repeats on each later cycle until a value from 0 to 2 comes up.
- R7: `victim_valid_o` goes high for one cycle, in the cycle after the clock edge of the successful draw, and it is never high together with `busy_o`.
- R8: A victim choice refreshes the chosen way in its group's tree, exactly as a hit to that way would.
- R9: A hit request whose way is 24 or above leaves all state unchanged and produces no output.
- R10: A request presented while `busy_o` is high is ignored. A retry always completes for the set of the miss that started it.
- R11: Each set's trees are independent: an access to one set never changes another set's victim choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, taken when `busy_o` is low |
| set_i | input | 4 | Set index of the request |
| hit_i | input | 1 | 1 = hit update, 0 = miss needing a victim |
| hit_way_i | input | 5 | Way that hit (0..23 legal) |
| victim_valid_o | output | 1 | One-cycle pulse: victim_way_o is valid |
| victim_way_o | output | 5 | Chosen victim way |
| busy_o | output | 1 | Group draw being retried, requests ignored |

## Verification
The bench targets the rejected draw. A design that let a value of 3 through would report ways 24..31. A design that did not hold the set would finish the retry on whatever set the intruding request named, and the bench injects such requests while `busy_o` is high so that this shows up. It also fills a group by hitting every way in turn and then checks the tree walk. A swapped node-bit polarity or a wrong child index would send the victim to a recently used leaf. Further checks use hits to ways 24 and 31, which must leave the next victim unchanged, and accesses to one set followed by misses on a neighbouring set, which catch trees shared or mis-addressed across sets.

// File: rtl/grp_plru_pkg.sv
package grp_plru_pkg;

   // Top-level selector state: idle or re-drawing a rejected group number
   typedef enum logic [0:0] {
      SEL_IDLE  = 1'b0,
      SEL_RETRY = 1'b1
   } sel_state_e;

endpackage

// File: rtl/grp_plru_tree.sv
// Combinational tree pseudo-LRU for one group: leaf walk and touch update.
module grp_plru_tree #(
   parameter int LEAVES = 8,
   localparam int LVL   = $clog2(LEAVES),
   localparam int NODES = LEAVES - 1
) (
   input  logic [NODES-1:0] tree_i,
   input  logic [LVL-1:0]   touch_leaf_i,
   output logic [LVL-1:0]   pick_leaf_o,
   output logic [NODES-1:0] tree_touched_o
);

   localparam logic [LVL-1:0] ONE = {{(LVL-1){1'b0}}, 1'b1};

   // R3: follow node bits from the root, 0 = left child, 1 = right child
   always_comb begin
      logic [LVL-1:0] node;
      node        = '0;
      pick_leaf_o = '0;
      for (int l = 0; l < LVL; l++) begin
         pick_leaf_o[LVL-1-l] = tree_i[node];
         node = (node << 1) + ONE + {{(LVL-1){1'b0}}, tree_i[node]};
      end
   end

   // R4/R8: every node on the touched path points to the other side
   always_comb begin
      logic [LVL-1:0] node;
      logic           b;
      node           = '0;
      tree_touched_o = tree_i;
      for (int l = 0; l < LVL; l++) begin
         b                    = touch_leaf_i[LVL-1-l];
         tree_touched_o[node] = ~b;
         node = (node << 1) + ONE + {{(LVL-1){1'b0}}, b};
      end
   end

endmodule

// File: rtl/grp_plru_lfsr.sv
// Galois LFSR supplying group draws; steps once per draw cycle.
module grp_plru_lfsr #(
   parameter int          W      = 16,
   parameter logic [W-1:0] TAPS  = 16'hB400,
   parameter logic [W-1:0] SEED  = 16'hACE1,
   parameter int          DRAW_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   output logic [DRAW_W-1:0] draw_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] state_nx;

   always_comb begin
      state_nx = {1'b0, state_q[W-1:1]};
      if (state_q[0]) state_nx = state_nx ^ TAPS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      state_q <= SEED;
      else if (step_i) state_q <= state_nx;
   end

   assign draw_o = state_q[DRAW_W-1:0];

   // R5: a Galois LFSR seeded nonzero never reaches the all-zero lock state
   a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

endmodule

// File: rtl/grp_plru_store.sv
// Per-set storage of all group trees; one read/write set per cycle.
module grp_plru_store #(
   parameter int SETS   = 16,
   parameter int GROUPS = 3,
   parameter int NODES  = 7,
   localparam int SET_W = $clog2(SETS),
   localparam int GRP_W = $clog2(GROUPS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SET_W-1:0]             set_i,
   output logic [GROUPS-1:0][NODES-1:0] trees_o,
   input  logic                         we_i,
   input  logic [GRP_W-1:0]             wr_group_i,
   input  logic [NODES-1:0]             wr_tree_i
);

   logic [GROUPS-1:0][NODES-1:0] mem_q [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem_q[s][g] <= '0;
            else if (we_i && set_i == SET_W'(s) && wr_group_i == GRP_W'(g))
               mem_q[s][g] <= wr_tree_i;
         end
      end
   end

   assign trees_o = mem_q[set_i];

endmodule

// File: rtl/grp_plru_sel.sv
// Random-group, per-group tree pseudo-LRU victim selector.
module grp_plru_sel
   import grp_plru_pkg::*;
#(
   parameter int           NUM_SETS   = 16,
   parameter int           NUM_GROUPS = 3,
   parameter int           GROUP_WAYS = 8,
   parameter int           LFSR_W     = 16,
   parameter logic [15:0]  LFSR_TAPS  = 16'hB400,
   parameter logic [15:0]  LFSR_SEED  = 16'hACE1,
   localparam int LEAF_W     = $clog2(GROUP_WAYS),
   localparam int NODES      = GROUP_WAYS - 1,
   localparam int GRP_W      = $clog2(NUM_GROUPS),
   localparam int WAY_W      = GRP_W + LEAF_W,
   localparam int SET_W      = $clog2(NUM_SETS),
   localparam int TOTAL_WAYS = NUM_GROUPS * GROUP_WAYS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [SET_W-1:0] set_i,
   input  logic             hit_i,
   input  logic [WAY_W-1:0] hit_way_i,
   output logic             victim_valid_o,
   output logic [WAY_W-1:0] victim_way_o,
   output logic             busy_o
);

   localparam logic [WAY_W:0] WAY_LIMIT = (WAY_W+1)'(TOTAL_WAYS);

   // Elaboration-time parameter checks
   if (GROUP_WAYS < 4 || (1 << LEAF_W) != GROUP_WAYS) begin : g_chk_ways
      $error("GROUP_WAYS must be a power of two, at least 4");
   end
   if (NUM_GROUPS < 2) begin : g_chk_groups
      $error("NUM_GROUPS must be at least 2");
   end
   if (NUM_SETS < 2 || (1 << SET_W) != NUM_SETS) begin : g_chk_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (LFSR_W != 16 || LFSR_W < GRP_W || LFSR_SEED == '0) begin : g_chk_lfsr
      $error("LFSR must be 16 bits wide with a nonzero seed");
   end

   sel_state_e       st_q;
   logic [SET_W-1:0] set_q;
   logic             vv_q;
   logic [WAY_W-1:0] way_q;

   logic             accept, hit_legal, miss_go, draw_en, draw_ok, we;
   logic [SET_W-1:0] cur_set;
   logic [GRP_W-1:0] draw, wr_group;
   logic [LEAF_W-1:0] touch_leaf, sel_leaf;
   logic [NODES-1:0] wr_tree;

   logic [NUM_GROUPS-1:0][NODES-1:0]  trees;
   logic [NUM_GROUPS-1:0][NODES-1:0]  touched;
   logic [NUM_GROUPS-1:0][LEAF_W-1:0] pick_leaf;

   assign accept    = req_i && (st_q == SEL_IDLE);
   assign hit_legal = accept && hit_i && ({1'b0, hit_way_i} < WAY_LIMIT);
   assign miss_go   = accept && !hit_i;
   assign draw_en   = miss_go || (st_q == SEL_RETRY);
   assign cur_set   = (st_q == SEL_RETRY) ? set_q : set_i;

   grp_plru_lfsr #(
      .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .DRAW_W(GRP_W)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step_i(draw_en), .draw_o(draw)
   );

   // A group count that fills the draw range never rejects
   if ((1 << GRP_W) == NUM_GROUPS) begin : g_draw_exact
      assign draw_ok = 1'b1;
   end else begin : g_draw_reject
      assign draw_ok = ({1'b0, draw} < (GRP_W+1)'(NUM_GROUPS));
   end

   grp_plru_store #(
      .SETS(NUM_SETS), .GROUPS(NUM_GROUPS), .NODES(NODES)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .set_i(cur_set), .trees_o(trees),
      .we_i(we), .wr_group_i(wr_group), .wr_tree_i(wr_tree)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_tree
      grp_plru_tree #(.LEAVES(GROUP_WAYS)) u_tree (
         .tree_i(trees[g]), .touch_leaf_i(touch_leaf),
         .pick_leaf_o(pick_leaf[g]), .tree_touched_o(touched[g])
      );
   end

   always_comb begin
      sel_leaf = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
         if (draw == GRP_W'(g)) sel_leaf = pick_leaf[g];
   end

   assign touch_leaf = hit_legal ? hit_way_i[LEAF_W-1:0] : sel_leaf;
   assign wr_group   = hit_legal ? hit_way_i[WAY_W-1:LEAF_W] : draw;
   assign we         = hit_legal || (draw_en && draw_ok);

   always_comb begin
      wr_tree = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
         if (wr_group == GRP_W'(g)) wr_tree = touched[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SEL_IDLE;
         set_q <= '0;
         vv_q  <= 1'b0;
         way_q <= '0;
      end else begin
         st_q <= (draw_en && !draw_ok) ? SEL_RETRY : SEL_IDLE;
         vv_q <= draw_en && draw_ok;
         if (draw_en) set_q <= cur_set;
         if (draw_en && draw_ok) way_q <= {draw, sel_leaf};
      end
   end

   assign victim_valid_o = vv_q;
   assign victim_way_o   = way_q;
   assign busy_o         = (st_q == SEL_RETRY);

   a_r7_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(victim_valid_o && busy_o));

   a_r2_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid_o |-> ({1'b0, victim_way_o} < WAY_LIMIT));

   a_r6_retry_ends_in_victim: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> victim_valid_o);

   a_r9_illegal_hit_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !busy_o && hit_i && ({1'b0, hit_way_i} >= WAY_LIMIT))
      |=> (!victim_valid_o && !busy_o));

   a_r4_hit_no_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !busy_o && hit_i) |=> !victim_valid_o);

endmodule

// File: tb/grp_plru_sel_test.sv
module grp_plru_sel_test;

   localparam int CLK_PERIOD = 10;
   localparam int SETS       = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0;
   logic [3:0] set_i = '0;
   logic       hit_i = 1'b0;
   logic [4:0] hit_way_i = '0;
   logic       victim_valid_o;
   logic [4:0] victim_way_o;
   logic       busy_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [6:0]  mt [SETS][3];
   logic [15:0] ml;

   always #(CLK_PERIOD/2) clk = ~clk;

   grp_plru_sel #(.NUM_SETS(SETS)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .set_i(set_i), .hit_i(hit_i),
      .hit_way_i(hit_way_i), .victim_valid_o(victim_valid_o),
      .victim_way_o(victim_way_o), .busy_o(busy_o)
   );

   function automatic logic [2:0] f_leaf(input logic [6:0] t);
      int n = 0;
      logic [2:0] lf = '0;
      for (int l = 0; l < 3; l++) begin
         lf[2-l] = t[n];
         n = 2*n + 1 + int'(t[n]);
      end
      return lf;
   endfunction

   function automatic logic [6:0] f_touch(input logic [6:0] t, input logic [2:0] lf);
      int n = 0;
      logic [6:0] r = t;
      for (int l = 0; l < 3; l++) begin
         r[n] = ~lf[2-l];
         n = 2*n + 1 + int'(lf[2-l]);
      end
      return r;
   endfunction

   function automatic logic [15:0] f_step(input logic [15:0] s);
      return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Entered and left at a falling edge
   task automatic do_hit(input int s, input int w);
      req_i = 1'b1; set_i = 4'(s); hit_i = 1'b1; hit_way_i = 5'(w);
      @(posedge clk); @(negedge clk);
      req_i = 1'b0;
      check(victim_valid_o == 1'b0, (w < 24) ? "R4 hit gives no victim" : "R9 illegal hit no victim",
            int'(victim_valid_o), 0);
      check(busy_o == 1'b0, "R4 hit not busy", int'(busy_o), 0);
      if (w < 24) mt[s][w/8] = f_touch(mt[s][w/8], 3'(w % 8));
   endtask

   task automatic do_miss(input int s, input bit inject, input string tag);
      logic [1:0] r;
      int exp;
      req_i = 1'b1; set_i = 4'(s); hit_i = 1'b0;
      @(posedge clk); @(negedge clk);
      req_i = 1'b0;
      for (int k = 0; k < 64; k++) begin
         r  = ml[1:0];
         ml = f_step(ml);
         if (r == 2'd3) begin
            check(busy_o == 1'b1, "R6 busy on rejected draw", int'(busy_o), 1);
            check(victim_valid_o == 1'b0, "R6 no victim on rejected draw", int'(victim_valid_o), 0);
            if (inject) begin
               // R10: intruding request while busy must be ignored
               req_i = 1'b1; set_i = 4'($urandom_range(15)); hit_i = $urandom_range(1);
               hit_way_i = 5'($urandom_range(23));
            end
            @(posedge clk); @(negedge clk);
            req_i = 1'b0;
         end else begin
            exp = int'(r) * 8 + int'(f_leaf(mt[s][r]));
            check(victim_valid_o == 1'b1, "R7 victim valid after draw", int'(victim_valid_o), 1);
            check(busy_o == 1'b0, "R7 not busy with victim", int'(busy_o), 0);
            check(int'(victim_way_o) == exp, tag, int'(victim_way_o), exp);
            check(victim_way_o < 5'd24, "R2 victim in range", int'(victim_way_o), exp);
            mt[s][r] = f_touch(mt[s][r], 3'(exp % 8));
            break;
         end
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4051);
      for (int s = 0; s < SETS; s++)
         for (int g = 0; g < 3; g++) mt[s][g] = '0;
      ml = 16'hACE1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(victim_valid_o == 1'b0, "R1 reset valid low", int'(victim_valid_o), 0);
      check(busy_o == 1'b0, "R1 reset busy low", int'(busy_o), 0);

      // R1/R3: fresh set points at leaf 0 of the drawn group
      do_miss(0, 1'b0, "R1 first victim from reset state");
      do_miss(1, 1'b0, "R5 draw from seeded LFSR");

      // R4/R3: touch every way of group 1 in set 2, then walk the trees
      for (int w = 8; w < 16; w++) do_hit(2, w);
      for (int i = 0; i < 6; i++) do_miss(2, 1'b0, "R3 tree walk after hits");

      // R9: illegal hit ways leave set 3 unchanged
      do_hit(3, 24);
      do_hit(3, 31);
      for (int i = 0; i < 4; i++) do_miss(3, 1'b0, "R9 state unchanged by illegal hit");

      // R11: traffic on set 5 must not move set 6
      for (int w = 0; w < 24; w += 3) do_hit(5, w);
      for (int i = 0; i < 4; i++) do_miss(6, 1'b0, "R11 neighbouring set untouched");

      // R8: consecutive misses on one set walk through refreshed leaves
      for (int i = 0; i < 10; i++) do_miss(7, 1'b1, "R8 fill refresh then R10 retry set");

      // Constrained random mix
      for (int i = 0; i < 600; i++) begin
         int op, s;
         op = $urandom_range(99);
         s  = $urandom_range(SETS-1);
         if (op < 40)      do_miss(s, 1'b1, "R10 victim after retry with intruders");
         else if (op < 90) do_hit(s, $urandom_range(23));
         else              do_hit(s, 24 + $urandom_range(7));
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule